// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects the data-memory request port of an 8-bit processor to an external parallel SRAM. The SRAM sees a shared 8-bit bus that carries the low address byte and then the data. It also sees a dedicated high-address byte, an address strobe that tells an external transparent latch to capture the low byte, and active-low read and write strobes. Each request is classified against the top of internal SRAM. Requests above that boundary go out over the pins. Requests at or below it go to internal memory through a simple select port.

While the interface is enabled, the block owns the output values and output enables of every pin it uses. An internal access still runs the address and address-strobe phases on the pins, but it never pulls the read or write strobe low. While the interface is disabled, the ordinary port values and directions pass through to the pads unchanged. An address above the boundary then completes without touching internal memory.

Requests enter on a valid/ready pair. The requester holds `req_valid` together with the address, write flag and write data, and keeps them stable until it sees `req_ready` high at a clock edge. `req_ready` is high only while the bus is idle, so a held request is the only back-pressure. The response is a one-clock `rsp_valid` pulse. It has no back-pressure and must be taken in that cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: An address greater than the parameter INT_TOP (default 0x10FF) is external. Any other address is internal. While enabled, an internal access raises `int_sel` for exactly one clock with `int_addr` equal to the request address.
- R2: In the first clock after a request is accepted with the interface enabled, ALE (`pad_ctl_o[0]`) is 1, all bits of `pad_ad_oe` are 1, and `pad_ad_o` carries the low address byte. ALE is high for that one clock only.
- R3: From the address clock through the response clock of an enabled access, `pad_ah_o` carries the high address byte and `pad_ah_oe` is all ones.
- R4: In the clock after ALE falls, ALE is 0 and `pad_ad_o` still drives the low address byte with all enables set. The data phase starts one clock later.
- R5: During an external write's data phase, WR_n (`pad_ctl_o[2]`) is 0, RD_n (`pad_ctl_o[1]`) is 1, and `pad_ad_o` drives the write data. RD_n and WR_n are never 0 together.
- R6: During an external read's data phase, `pad_ad_oe` is 0 and RD_n is 0. The value on `pad_ad_i` at the clock edge where RD_n returns high is returned on `rsp_rdata`.
- R7: While enabled, an internal access produces the same address and ALE sequence as an external one. Its data phase lasts one clock, and RD_n and WR_n stay 1. A read returns `int_rdata` sampled in that clock.
- R8: The data phase of an external access lasts 1 + `wait_cfg` clocks, for `wait_cfg` from 0 to 3.
- R9: While `xm_en` is 1, every output and output-enable of the AD, AH and control pads is driven by the block, and the AH and control enables are all ones. While `xm_en` is 0, each pad output and enable equals its `gpio_*` counterpart.
- R10: While disabled, an internal access raises `int_sel` for one clock, and `rsp_valid` follows in the next clock. An access above the boundary never raises `int_sel` and responds in the clock after acceptance with `rsp_rdata` equal to 0.
- R11: `req_ready` is 1 only in the idle state. A request is accepted at an edge where both `req_valid` and `req_ready` are 1. Every accepted request yields exactly one single-clock `rsp_valid` pulse, after which the block returns to idle. Writes respond with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xm_en | input | 1 | Interface enable; change only while idle |
| wait_cfg | input | 2 | Extra strobe clocks for external accesses |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 16 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| int_sel | output | 1 | Internal memory select |
| int_we | output | 1 | Internal write flag |
| int_addr | output | 16 | Internal address |
| int_wdata | output | 8 | Internal write data |
| int_rdata | input | 8 | Internal read data |
| gpio_ad_o | input | 8 | Normal port value, AD pins |
| gpio_ad_oe | input | 8 | Normal direction, AD pins |
| gpio_ah_o | input | 8 | Normal port value, AH pins |
| gpio_ah_oe | input | 8 | Normal direction, AH pins |
| gpio_ctl_o | input | 3 | Normal port value, control pins |
| gpio_ctl_oe | input | 3 | Normal direction, control pins |
| pad_ad_o | output | 8 | AD pad output value |
| pad_ad_oe | output | 8 | AD pad output enable |
| pad_ad_i | input | 8 | AD pad input value |
| pad_ah_o | output | 8 | High address pad value |
| pad_ah_oe | output | 8 | High address pad enable |
| pad_ctl_o | output | 3 | Control pads: bit0 ALE, bit1 RD_n, bit2 WR_n |
| pad_ctl_oe | output | 3 | Control pad enables |

## Verification
The hardest state to reach from the ports is a request that is already waiting while the previous access is still inside a stretched strobe. It must be held off for the whole stretch and then accepted on the first idle clock. The bench issues a second request right after the first one is accepted, with the largest wait count, so the second request stands valid through every busy clock. Boundary addresses on both sides of the internal top are used with the interface enabled and disabled. An enable change between accesses shows the pads switching between block control and passthrough.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_DATA,
    ST_DONE
  } xbus_state_e;

  localparam int CTL_ALE = 0;
  localparam int CTL_RD  = 1;
  localparam int CTL_WR  = 2;
  localparam int NCTL    = 3;

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int          AW      = 16,
  parameter logic [15:0] INT_TOP = 16'h10FF
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  output logic          ext_hit,
  output logic          unmapped
);

  localparam logic [AW-1:0] TOP_W = AW'(INT_TOP);

  always_comb begin
    ext_hit  = (addr > TOP_W);
    unmapped = ext_hit && !en;
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [WS_W-1:0] wait_cfg,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_we,
  input  logic [DW-1:0]   req_wdata,
  input  logic            ext_hit,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            int_sel,
  output logic            int_we,
  output logic [AW-1:0]   int_addr,
  output logic [DW-1:0]   int_wdata,
  input  logic [DW-1:0]   int_rdata,
  input  logic [DW-1:0]   ad_in,
  output logic            bus_ale,
  output logic [DW-1:0]   bus_ad_drv,
  output logic            bus_ad_oe,
  output logic [AW-DW-1:0] bus_ah,
  output logic            bus_rd_n,
  output logic            bus_wr_n
);

  xbus_state_e       state_q;
  logic [AW-1:0]     addr_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q;
  logic              ext_q;
  logic [WS_W-1:0]   wcnt_q;
  logic [DW-1:0]     rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      ext_q   <= 1'b0;
      wcnt_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
            ext_q   <= ext_hit && en;
            wcnt_q  <= (ext_hit && en) ? wait_cfg : '0;
            rdata_q <= '0;
            if (en)           state_q <= ST_ADDR;
            else if (ext_hit) state_q <= ST_DONE;
            else              state_q <= ST_DATA;
          end
        end
        ST_ADDR: state_q <= ST_HOLD;
        ST_HOLD: state_q <= ST_DATA;
        ST_DATA: begin
          if (wcnt_q == '0) begin
            if (!we_q) rdata_q <= ext_q ? ad_in : int_rdata;
            state_q <= ST_DONE;
          end else begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    rsp_valid  = (state_q == ST_DONE);
    rsp_rdata  = rdata_q;
    int_sel    = (state_q == ST_DATA) && !ext_q;
    int_we     = we_q;
    int_addr   = addr_q;
    int_wdata  = wdata_q;
    bus_ale    = (state_q == ST_ADDR);
    bus_ah     = addr_q[AW-1:DW];
    bus_ad_drv = '0;
    bus_ad_oe  = 1'b0;
    bus_rd_n   = 1'b1;
    bus_wr_n   = 1'b1;
    case (state_q)
      ST_ADDR, ST_HOLD: begin
        bus_ad_drv = addr_q[DW-1:0];
        bus_ad_oe  = 1'b1;
      end
      ST_DATA: begin
        bus_ad_drv = wdata_q;
        bus_ad_oe  = we_q;
        bus_rd_n   = !(ext_q && !we_q);
        bus_wr_n   = !(ext_q && we_q);
      end
      default: ;
    endcase
  end

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (bus_ad_oe && bus_ad_drv == $past(bus_ad_drv)));

  a_r3_high_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> $stable(bus_ah));

  a_r7_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (bus_rd_n && bus_wr_n));

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_single_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

endmodule

// File: rtl/xbus_pinmux.sv
module xbus_pinmux #(
  parameter int NP = 19
) (
  input  logic          en,
  input  logic [NP-1:0] blk_o,
  input  logic [NP-1:0] blk_oe,
  input  logic [NP-1:0] gp_o,
  input  logic [NP-1:0] gp_oe,
  output logic [NP-1:0] pad_o,
  output logic [NP-1:0] pad_oe
);

  for (genvar gi = 0; gi < NP; gi++) begin : g_pin
    assign pad_o[gi]  = en ? blk_o[gi]  : gp_o[gi];
    assign pad_oe[gi] = en ? blk_oe[gi] : gp_oe[gi];
  end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int          AW      = 16,
  parameter int          DW      = 8,
  parameter int          WS_W    = 2,
  parameter logic [15:0] INT_TOP = 16'h10FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xm_en,
  input  logic [WS_W-1:0]  wait_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_we,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             int_sel,
  output logic             int_we,
  output logic [AW-1:0]    int_addr,
  output logic [DW-1:0]    int_wdata,
  input  logic [DW-1:0]    int_rdata,
  input  logic [DW-1:0]    gpio_ad_o,
  input  logic [DW-1:0]    gpio_ad_oe,
  input  logic [AW-DW-1:0] gpio_ah_o,
  input  logic [AW-DW-1:0] gpio_ah_oe,
  input  logic [NCTL-1:0]  gpio_ctl_o,
  input  logic [NCTL-1:0]  gpio_ctl_oe,
  output logic [DW-1:0]    pad_ad_o,
  output logic [DW-1:0]    pad_ad_oe,
  input  logic [DW-1:0]    pad_ad_i,
  output logic [AW-DW-1:0] pad_ah_o,
  output logic [AW-DW-1:0] pad_ah_oe,
  output logic [NCTL-1:0]  pad_ctl_o,
  output logic [NCTL-1:0]  pad_ctl_oe
);

  localparam int HW = AW - DW;
  localparam int NP = DW + HW + NCTL;

  logic          ext_hit, unmapped;
  logic          bus_ale, bus_ad_oe, bus_rd_n, bus_wr_n;
  logic [DW-1:0] bus_ad_drv;
  logic [HW-1:0] bus_ah;
  logic [NCTL-1:0] ctl_blk;
  logic [NP-1:0] blk_o, blk_oe, gp_o, gp_oe, mux_o, mux_oe;

  xbus_decode #(.AW(AW), .INT_TOP(INT_TOP)) u_decode (
    .addr     (req_addr),
    .en       (xm_en),
    .ext_hit  (ext_hit),
    .unmapped (unmapped)
  );

  xbus_seq #(.AW(AW), .DW(DW), .WS_W(WS_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (xm_en),
    .wait_cfg   (wait_cfg),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_we     (req_we),
    .req_wdata  (req_wdata),
    .ext_hit    (ext_hit),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .int_sel    (int_sel),
    .int_we     (int_we),
    .int_addr   (int_addr),
    .int_wdata  (int_wdata),
    .int_rdata  (int_rdata),
    .ad_in      (pad_ad_i),
    .bus_ale    (bus_ale),
    .bus_ad_drv (bus_ad_drv),
    .bus_ad_oe  (bus_ad_oe),
    .bus_ah     (bus_ah),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n)
  );

  always_comb begin
    ctl_blk          = '1;
    ctl_blk[CTL_ALE] = bus_ale;
    ctl_blk[CTL_RD]  = bus_rd_n;
    ctl_blk[CTL_WR]  = bus_wr_n;
    blk_o  = {ctl_blk, bus_ah, bus_ad_drv};
    blk_oe = {{NCTL{1'b1}}, {HW{1'b1}}, {DW{bus_ad_oe}}};
    gp_o   = {gpio_ctl_o, gpio_ah_o, gpio_ad_o};
    gp_oe  = {gpio_ctl_oe, gpio_ah_oe, gpio_ad_oe};
  end

  xbus_pinmux #(.NP(NP)) u_pinmux (
    .en     (xm_en),
    .blk_o  (blk_o),
    .blk_oe (blk_oe),
    .gp_o   (gp_o),
    .gp_oe  (gp_oe),
    .pad_o  (mux_o),
    .pad_oe (mux_oe)
  );

  always_comb begin
    pad_ad_o   = mux_o[DW-1:0];
    pad_ad_oe  = mux_oe[DW-1:0];
    pad_ah_o   = mux_o[DW+HW-1:DW];
    pad_ah_oe  = mux_oe[DW+HW-1:DW];
    pad_ctl_o  = mux_o[NP-1:DW+HW];
    pad_ctl_oe = mux_oe[NP-1:DW+HW];
  end

  a_r10_unmapped_skips_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && unmapped) |=> (!int_sel && rsp_valid && rsp_rdata == '0));

  a_r9_enabled_owns_control: assert property (@(posedge clk) disable iff (!rst_n)
    xm_en |-> (pad_ctl_oe == '1 && pad_ah_oe == '1));

endmodule

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

  localparam logic [15:0] TOP = 16'h10FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        xm_en;
  logic [1:0]  wait_cfg;
  logic        req_valid, req_ready, req_we;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        int_sel, int_we;
  logic [15:0] int_addr;
  logic [7:0]  int_wdata, int_rdata;
  logic [7:0]  gpio_ad_o, gpio_ad_oe, gpio_ah_o, gpio_ah_oe;
  logic [2:0]  gpio_ctl_o, gpio_ctl_oe;
  logic [7:0]  pad_ad_o, pad_ad_oe, pad_ah_o, pad_ah_oe;
  logic [7:0]  pad_ad_i = 8'hFF;
  logic [2:0]  pad_ctl_o, pad_ctl_oe;

  always #5 clk = ~clk;

  xbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .xm_en(xm_en), .wait_cfg(wait_cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .int_sel(int_sel), .int_we(int_we),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
    .gpio_ad_o(gpio_ad_o), .gpio_ad_oe(gpio_ad_oe), .gpio_ah_o(gpio_ah_o),
    .gpio_ah_oe(gpio_ah_oe), .gpio_ctl_o(gpio_ctl_o), .gpio_ctl_oe(gpio_ctl_oe),
    .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_ad_i(pad_ad_i),
    .pad_ah_o(pad_ah_o), .pad_ah_oe(pad_ah_oe), .pad_ctl_o(pad_ctl_o),
    .pad_ctl_oe(pad_ctl_oe)
  );

  assign int_rdata = int_addr[7:0] ^ 8'hC3;

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // external SRAM behind a transparent latch
  logic [7:0] sram [int];
  logic [7:0] lat = 8'h00;

  function automatic logic [7:0] sread(input logic [15:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : dflt(a);
  endfunction

  always @(posedge clk) begin
    if (xm_en && pad_ctl_o[0]) lat <= pad_ad_o;
    if (xm_en && !pad_ctl_o[2]) sram[int'({pad_ah_o, lat})] = pad_ad_o;
  end

  always @(negedge clk)
    pad_ad_i <= (xm_en && !pad_ctl_o[1]) ? sread({pad_ah_o, lat}) : 8'hFF;

  // behavioural reference: per-cycle expectation queue
  typedef struct {
    bit          rdy;
    bit          ale;
    bit          adoe;
    logic [7:0]  ad;
    bit          ahchk;
    logic [7:0]  ah;
    bit          rd_n;
    bit          wr_n;
    bit          isel;
    logic [15:0] iaddr;
    bit          rv;
    logic [7:0]  rdata;
    string       tag;
  } rec_t;

  rec_t exp_q[$];
  logic [7:0] exp_mem [int];
  bit exp_rdy = 1'b1;

  function automatic rec_t idle_rec();
    rec_t r;
    r.rdy = 1; r.ale = 0; r.adoe = 0; r.ad = 0; r.ahchk = 0; r.ah = 0;
    r.rd_n = 1; r.wr_n = 1; r.isel = 0; r.iaddr = 0; r.rv = 0; r.rdata = 0;
    r.tag = "R11 idle";
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst_n && exp_rdy && req_valid) begin
      rec_t r;
      logic [15:0] a;
      bit ext;
      int n;
      a = req_addr;
      ext = (a > TOP);
      r = idle_rec();
      r.rdy = 0;
      r.ah = a[15:8];
      if (xm_en) begin
        r.ahchk = 1;
        r.ale = 1; r.adoe = 1; r.ad = a[7:0]; r.tag = "R2 address phase";
        exp_q.push_back(r);
        r.ale = 0; r.tag = "R4 address hold";
        exp_q.push_back(r);
        n = ext ? 1 + int'(wait_cfg) : 1;
        r.adoe = req_we; r.ad = req_wdata;
        r.rd_n = !(ext && !req_we); r.wr_n = !(ext && req_we);
        r.isel = !ext; r.iaddr = a;
        r.tag = ext ? (req_we ? "R5/R8 write strobe" : "R6/R8 read strobe") : "R7 internal data";
        for (int i = 0; i < n; i++) exp_q.push_back(r);
        if (ext && req_we) exp_mem[int'(a)] = req_wdata;
      end else if (!ext) begin
        r.isel = 1; r.iaddr = a; r.tag = "R10 disabled internal";
        exp_q.push_back(r);
      end
      r.adoe = 0; r.ale = 0; r.rd_n = 1; r.wr_n = 1; r.isel = 0; r.rv = 1;
      if (req_we) r.rdata = 8'h00;
      else if (!ext) r.rdata = a[7:0] ^ 8'hC3;
      else if (xm_en) r.rdata = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
      else r.rdata = 8'h00;
      r.tag = ext ? (xm_en ? "R6 response" : "R10 unmapped response") : "R7 response";
      exp_q.push_back(r);
    end
  end

  always @(negedge clk) begin
    rec_t e;
    if (!rst_n) begin
      exp_rdy = 1'b1;
    end else begin
      e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_rec();
      exp_rdy = e.rdy;
      chk({e.tag, " R11 req_ready"}, req_ready, e.rdy);
      chk({e.tag, " R11 rsp_valid"}, rsp_valid, e.rv);
      if (e.rv) chk({e.tag, " rsp_rdata"}, rsp_rdata, e.rdata);
      chk({e.tag, " R1 int_sel"}, int_sel, e.isel);
      if (e.isel) chk({e.tag, " R1 int_addr"}, int_addr, e.iaddr);
      if (xm_en) begin
        chk({e.tag, " R2 ALE"}, pad_ctl_o[0], e.ale);
        chk({e.tag, " R5 RD_n"}, pad_ctl_o[1], e.rd_n);
        chk({e.tag, " R5 WR_n"}, pad_ctl_o[2], e.wr_n);
        chk({e.tag, " R9 ctl_oe"}, pad_ctl_oe, 3'b111);
        chk({e.tag, " R9 ah_oe"}, pad_ah_oe, 8'hFF);
        chk({e.tag, " R6 ad_oe"}, pad_ad_oe, {8{e.adoe}});
        if (e.adoe) chk({e.tag, " R4 ad_o"}, pad_ad_o, e.ad);
        if (e.ahchk) chk({e.tag, " R3 ah_o"}, pad_ah_o, e.ah);
      end else begin
        chk({e.tag, " R9 pass ad_o"}, pad_ad_o, gpio_ad_o);
        chk({e.tag, " R9 pass ad_oe"}, pad_ad_oe, gpio_ad_oe);
        chk({e.tag, " R9 pass ah_o"}, pad_ah_o, gpio_ah_o);
        chk({e.tag, " R9 pass ah_oe"}, pad_ah_oe, gpio_ah_oe);
        chk({e.tag, " R9 pass ctl_o"}, pad_ctl_o, gpio_ctl_o);
        chk({e.tag, " R9 pass ctl_oe"}, pad_ctl_oe, gpio_ctl_oe);
      end
    end
  end

  task automatic issue(input logic [15:0] a, input logic we, input logic [7:0] d);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; xm_en = 1'b1; wait_cfg = 2'd0;
    req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_wdata = '0;
    gpio_ad_o = 8'hA5; gpio_ad_oe = 8'h0F; gpio_ah_o = 8'h3C; gpio_ah_oe = 8'hF0;
    gpio_ctl_o = 3'b101; gpio_ctl_oe = 3'b010;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R1 R2 R4 R5 R6: external accesses, no wait states
    issue(16'h2034, 1'b1, 8'h9E); wait_idle();
    issue(16'h2034, 1'b0, 8'h00); wait_idle();
    issue(16'h8001, 1'b0, 8'h00); wait_idle();
    // R7: internal accesses while enabled, boundary on both sides (R1)
    issue(16'h0100, 1'b1, 8'h44); wait_idle();
    issue(16'h10FF, 1'b0, 8'h00); wait_idle();
    issue(16'h1100, 1'b0, 8'h00); wait_idle();
    issue(16'hFFFF, 1'b1, 8'h01); wait_idle();
    issue(16'hFFFF, 1'b0, 8'h00); wait_idle();

    // R8: each wait-state setting
    for (int w = 1; w < 4; w++) begin
      wait_cfg = 2'(w);
      issue(16'h4000 + 16'(w), 1'b1, 8'(8'h70 + w)); wait_idle();
      issue(16'h4000 + 16'(w), 1'b0, 8'h00); wait_idle();
    end

    // R11: second request held off through a stretched strobe
    wait_cfg = 2'd3;
    issue(16'h5A5A, 1'b1, 8'hC1);
    issue(16'h5A5A, 1'b0, 8'h00);
    issue(16'h0042, 1'b0, 8'h00);
    wait_idle();

    // R9 R10: disabled interface
    xm_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    issue(16'h0200, 1'b0, 8'h00); wait_idle();
    issue(16'h10FF, 1'b1, 8'h33); wait_idle();
    issue(16'h9000, 1'b0, 8'h00); wait_idle();
    issue(16'h1100, 1'b1, 8'h77); wait_idle();
    gpio_ad_o = 8'h5A; gpio_ctl_o = 3'b010; gpio_ctl_oe = 3'b101;
    repeat (2) @(posedge clk);
    #1;

    // back to enabled: earlier external write still in place (R6)
    xm_en = 1'b1; wait_cfg = 2'd0;
    issue(16'h2034, 1'b0, 8'h00); wait_idle();
    issue(16'h1100, 1'b0, 8'h00); wait_idle();

    finish_run();
  end

endmodule